// File: doc/BRIEF.md
# Serial Command-Interpreter Register Slave

This block is a two-wire serial slave that runs entirely on a fast system clock. It oversamples the serial clock and data lines and finds the START, STOP and bit edges itself. It drives the data line only through an active-high pull-down enable. A transfer carries a 7-bit slave address with a direction bit, then a command byte, then optional data bytes.

An internal interpreter decodes the command byte. Valid commands act on an 8-bit control/status register at once. The commands are: put the downstream circuit to sleep, wake it, clear the control/status register, or open the next data byte as a write into an 8-bit frequency register.

A read transfer returns the control/status register. Downstream logic uses the two register values and a power-down flag.

Top module: `cmdreg_top`

## Requirements
- R1: After reset, ctrl_o = 0x00, freq_o = 0x80, pdown_o = 0 and sda_oe = 0.
- R2: The address byte is ACKed only when its upper seven bits equal SLAVE_ADDR (default 0x2C). Bit 0 of that byte selects the direction: 0 is write, 1 is read. On a mismatch the byte is NACKed and every later byte up to the next START or STOP is ignored.
- R3: Command 0x01 sets ctrl_o bit 0 (the power-down bit) and raises pdown_o.
- R4: Command 0x02 clears ctrl_o bit 0 and pdown_o. The frequency register keeps the value it held before power-down.
- R5: After command 0x10, the first data byte of the same transfer is ACKed and loaded into freq_o, and ctrl_o bit 1 (the frequency-loaded flag) is set.
- R6: No other data byte is ACKed and none changes freq_o. This covers data after any other command and a second data byte after 0x10.
- R7: Command 0x03 returns ctrl_o to 0x00 and leaves freq_o unchanged.
- R8: A command byte other than 0x00, 0x01, 0x02, 0x03 or 0x10 is NACKed and changes no register. Command 0x00 is ACKed and changes nothing.
- R9: A read transfer returns ctrl_o MSB first. Another copy follows each time the master ACKs, and output ends when the master NACKs.
- R10: The serial interface keeps working while power-down is set. A frequency write made during power-down takes effect.
- R11: A repeated START ends the current transfer and starts address decoding again.
- R12: The slave begins pulling SDA low only while SCL is low. It releases SDA after each acknowledge or data byte, and on STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Active-low power-on reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| ctrl_o | output | 8 | Control/status register |
| freq_o | output | 8 | Frequency register |
| pdown_o | output | 1 | Power-down flag for downstream logic |

## Verification
Line levels pass through two synchronizer flops and one edge-history flop before an edge is seen. The register update or SDA drive follows one cycle later, so every result lands about four system clocks after the SCL or SDA edge that causes it. The bench spaces each SCL phase by ten system clocks. It samples acknowledge and read data in the middle of the SCL high time and checks register outputs only after STOP. Every sample therefore falls well clear of that four-cycle latency and of the clock edge itself.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
    localparam int BYTE_W   = 8;
    localparam int PD_BIT   = 0;
    localparam int LOAD_BIT = 1;

    localparam logic [BYTE_W-1:0] CMD_NOP   = 8'h00;
    localparam logic [BYTE_W-1:0] CMD_SLEEP = 8'h01;
    localparam logic [BYTE_W-1:0] CMD_WAKE  = 8'h02;
    localparam logic [BYTE_W-1:0] CMD_SRST  = 8'h03;
    localparam logic [BYTE_W-1:0] CMD_FREQ  = 8'h10;

    typedef enum logic [2:0] {
        PH_IDLE, PH_RX, PH_ACK, PH_TX, PH_MACK, PH_SKIP
    } phase_e;

    // position of a received byte inside a transfer
    typedef enum logic [1:0] {
        IDX_ADDR, IDX_CMD, IDX_DATA, IDX_MORE
    } idx_e;
endpackage

// File: rtl/cmdreg_sync.sv
module cmdreg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    typedef struct packed {
        logic [STAGES-1:0] scl;
        logic [STAGES-1:0] sda;
        logic              scl_old;
        logic              sda_old;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.scl     = {s_q.scl[STAGES-2:0], scl_i};
        s_d.sda     = {s_q.sda[STAGES-2:0], sda_i};
        s_d.scl_old = s_q.scl[STAGES-1];
        s_d.sda_old = s_q.sda[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_o     = s_q.scl[STAGES-1];
    assign sda_o     = s_q.sda[STAGES-1];
    assign scl_rise  = scl_o & ~s_q.scl_old;
    assign scl_fall  = ~scl_o & s_q.scl_old;
    assign bus_start = scl_o & s_q.scl_old & s_q.sda_old & ~sda_o;
    assign bus_stop  = scl_o & s_q.scl_old & ~s_q.sda_old & sda_o;
endmodule

// File: rtl/cmdreg_link.sv
module cmdreg_link
    import cmdreg_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h2C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              ack_ok,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              byte_vld,
    output idx_e              byte_idx,
    output logic [BYTE_W-1:0] byte_val
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_W - 1);
    localparam logic [3:0] FULL     = 4'(BYTE_W);

    typedef struct packed {
        phase_e            phase;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] sh;
        idx_e              idx;
        logic              rd;
        logic              more;
        logic              oe;
    } link_t;

    link_t l_d, l_q;
    logic  take;

    assign byte_vld = (l_q.phase == PH_RX) && scl_fall && (l_q.cnt == FULL);
    assign byte_idx = l_q.idx;
    assign byte_val = l_q.sh;
    assign take     = (l_q.idx == IDX_ADDR) ? (l_q.sh[BYTE_W-1:1] == SLAVE_ADDR) : ack_ok;
    assign sda_oe   = l_q.oe;

    always_comb begin
        l_d = l_q;
        if (bus_start) begin
            l_d.phase = PH_RX;
            l_d.cnt   = '0;
            l_d.idx   = IDX_ADDR;
            l_d.rd    = 1'b0;
            l_d.oe    = 1'b0;
        end else if (bus_stop) begin
            l_d.phase = PH_IDLE;
            l_d.oe    = 1'b0;
        end else begin
            case (l_q.phase)
                PH_RX: begin
                    if (scl_rise && l_q.cnt != FULL) begin
                        l_d.sh  = {l_q.sh[BYTE_W-2:0], sda_s};
                        l_d.cnt = l_q.cnt + 4'd1;
                    end
                    if (byte_vld) begin
                        if (take) begin
                            l_d.phase = PH_ACK;
                            l_d.oe    = 1'b1;
                            if (l_q.idx == IDX_ADDR) l_d.rd = l_q.sh[0];
                        end else begin
                            l_d.phase = PH_SKIP;
                        end
                    end
                end
                PH_ACK: if (scl_fall) begin
                    l_d.cnt = '0;
                    if (l_q.rd) begin
                        l_d.phase = PH_TX;
                        l_d.sh    = rd_data;
                        l_d.oe    = ~rd_data[BYTE_W-1];
                    end else begin
                        l_d.phase = PH_RX;
                        l_d.oe    = 1'b0;
                        l_d.idx   = (l_q.idx == IDX_MORE) ? IDX_MORE : idx_e'(l_q.idx + 2'd1);
                    end
                end
                PH_TX: if (scl_fall) begin
                    if (l_q.cnt == LAST_BIT) begin
                        l_d.phase = PH_MACK;
                        l_d.oe    = 1'b0;
                    end else begin
                        l_d.cnt = l_q.cnt + 4'd1;
                        l_d.sh  = {l_q.sh[BYTE_W-2:0], 1'b0};
                        l_d.oe  = ~l_q.sh[BYTE_W-2];
                    end
                end
                PH_MACK: begin
                    if (scl_rise) l_d.more = ~sda_s;
                    if (scl_fall) begin
                        if (l_q.more) begin
                            l_d.phase = PH_TX;
                            l_d.cnt   = '0;
                            l_d.sh    = rd_data;
                            l_d.oe    = ~rd_data[BYTE_W-1];
                        end else begin
                            l_d.phase = PH_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '{phase: PH_IDLE, idx: IDX_ADDR, default: '0};
        else        l_q <= l_d;
    end
endmodule

// File: rtl/cmdreg_decode.sv
module cmdreg_decode
    import cmdreg_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CTRL_RST = 8'h00,
    parameter logic [BYTE_W-1:0] FREQ_RST = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  idx_e              byte_idx,
    input  logic [BYTE_W-1:0] byte_val,
    output logic              ack_ok,
    output logic [BYTE_W-1:0] ctrl_o,
    output logic [BYTE_W-1:0] freq_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] freq;
        logic              arm;
    } regs_t;

    regs_t r_d, r_q;
    logic  cmd_ok;

    always_comb begin
        case (byte_val)
            CMD_NOP, CMD_SLEEP, CMD_WAKE, CMD_SRST, CMD_FREQ: cmd_ok = 1'b1;
            default:                                          cmd_ok = 1'b0;
        endcase
    end

    assign ack_ok = (byte_idx == IDX_CMD)  ? cmd_ok :
                    (byte_idx == IDX_DATA) ? r_q.arm : 1'b0;

    always_comb begin
        r_d = r_q;
        if (byte_vld) begin
            case (byte_idx)
                IDX_ADDR: r_d.arm = 1'b0;
                IDX_CMD: if (cmd_ok) begin
                    r_d.arm = (byte_val == CMD_FREQ);
                    case (byte_val)
                        CMD_SLEEP: r_d.ctrl[PD_BIT] = 1'b1;
                        CMD_WAKE:  r_d.ctrl[PD_BIT] = 1'b0;
                        CMD_SRST:  r_d.ctrl         = CTRL_RST;
                        default: ;
                    endcase
                end
                IDX_DATA: if (r_q.arm) begin
                    r_d.freq          = byte_val;
                    r_d.ctrl[LOAD_BIT] = 1'b1;
                    r_d.arm           = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{ctrl: CTRL_RST, freq: FREQ_RST, arm: 1'b0};
        else        r_q <= r_d;
    end

    assign ctrl_o = r_q.ctrl;
    assign freq_o = r_q.freq;
endmodule

// File: rtl/cmdreg_top.sv
module cmdreg_top
    import cmdreg_pkg::*;
#(
    parameter logic [6:0]        SLAVE_ADDR  = 7'h2C,
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] CTRL_RST    = 8'h00,
    parameter logic [BYTE_W-1:0] FREQ_RST    = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] ctrl_o,
    output logic [BYTE_W-1:0] freq_o,
    output logic              pdown_o
);
    logic              scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic              ack_ok, byte_vld;
    idx_e              byte_idx;
    logic [BYTE_W-1:0] byte_val;

    cmdreg_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    cmdreg_link #(.SLAVE_ADDR(SLAVE_ADDR)) i_link (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall & ~scl_s), .bus_start(bus_start), .bus_stop(bus_stop),
        .ack_ok(ack_ok), .rd_data(ctrl_o), .sda_oe(sda_oe), .byte_vld(byte_vld),
        .byte_idx(byte_idx), .byte_val(byte_val)
    );

    cmdreg_decode #(.CTRL_RST(CTRL_RST), .FREQ_RST(FREQ_RST)) i_decode (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_idx(byte_idx),
        .byte_val(byte_val), .ack_ok(ack_ok), .ctrl_o(ctrl_o), .freq_o(freq_o)
    );

    assign pdown_o = ctrl_o[PD_BIT];
endmodule

// File: rtl/cmdreg_chk.sv
module cmdreg_chk
    import cmdreg_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CTRL_RST = 8'h00
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              byte_vld,
    input idx_e              byte_idx,
    input logic [BYTE_W-1:0] byte_val,
    input logic [BYTE_W-1:0] ctrl_o,
    input logic [BYTE_W-1:0] freq_o,
    input logic              pdown_o
);
    logic cmd_evt, known;
    assign cmd_evt = byte_vld && (byte_idx == IDX_CMD);
    assign known   = (byte_val == 8'h00) || (byte_val == 8'h01) || (byte_val == 8'h02) ||
                     (byte_val == 8'h03) || (byte_val == 8'h10);

    AST_SLEEP_SETS_PD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_evt && byte_val == 8'h01) |=> pdown_o);  // R3

    AST_FREQ_ONLY_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(freq_o) |-> $past(byte_vld && byte_idx == IDX_DATA));  // R6

    AST_SRST_KEEPS_FREQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_evt && byte_val == 8'h03) |=> (ctrl_o == CTRL_RST && $stable(freq_o)));  // R7

    AST_UNDEF_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_evt && !known) |=> ($stable(ctrl_o) && $stable(freq_o)));  // R8

    AST_OE_RISES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);  // R12
endmodule

bind cmdreg_top cmdreg_chk #(.CTRL_RST(CTRL_RST)) i_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .byte_vld(byte_vld),
    .byte_idx(byte_idx), .byte_val(byte_val), .ctrl_o(ctrl_o), .freq_o(freq_o),
    .pdown_o(pdown_o)
);

// File: tb/test_cmdreg_top.sv
module test_cmdreg_top;
    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 10;   // system clocks per quarter SCL period
    localparam logic [6:0] ADDR       = 7'h2C;

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] dat;
        logic       has_dat;
        logic       ack_c;
        logic       ack_d;
        logic [7:0] ctrl;
        logic [7:0] freq;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        {8'h01, 8'h00, 1'b0, 1'b1, 1'b0, 8'h01, 8'h80},  // R3 sleep
        {8'h10, 8'h5A, 1'b1, 1'b1, 1'b1, 8'h03, 8'h5A},  // R5 R10 freq write while asleep
        {8'h02, 8'h00, 1'b0, 1'b1, 1'b0, 8'h02, 8'h5A},  // R4 wake keeps freq
        {8'h00, 8'h33, 1'b1, 1'b1, 1'b0, 8'h02, 8'h5A},  // R6 R8 data after no-op refused
        {8'h7E, 8'h00, 1'b0, 1'b0, 1'b0, 8'h02, 8'h5A},  // R8 undefined command
        {8'h03, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 8'h5A},  // R7 soft reset keeps freq
        {8'h10, 8'hA5, 1'b1, 1'b1, 1'b1, 8'h02, 8'hA5},  // R5 second load
        {8'h01, 8'h00, 1'b0, 1'b1, 1'b0, 8'h03, 8'hA5}   // R3 sleep again
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_line;
    logic       sda_oe, pdown_o;
    logic [7:0] ctrl_o, freq_o;
    int         n_chk = 0;
    int         n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    cmdreg_top i_cmdreg_top (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .ctrl_o(ctrl_o), .freq_o(freq_o), .pdown_o(pdown_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic qwait(input int n = 1);
        repeat (n * Q) @(posedge clk);
        #1;
    endtask

    task automatic do_start();
        m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait(); m_sda = 1'b0; qwait(); m_scl = 1'b0; qwait();
    endtask

    task automatic do_stop();
        m_sda = 1'b0; qwait(); m_scl = 1'b1; qwait(); m_sda = 1'b1; qwait(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; qwait(); m_scl = 1'b1; qwait(2); m_scl = 1'b0; qwait();
        end
        m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait(); ack = ~sda_line; qwait(); m_scl = 1'b0; qwait();
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qwait(); m_scl = 1'b1; qwait(); b[i] = sda_line; qwait(); m_scl = 1'b0; qwait();
        end
        m_sda = ~mack; qwait(); m_scl = 1'b1; qwait(2); m_scl = 1'b0; qwait();
    endtask

    task automatic write_txn(input logic [6:0] a, input logic [7:0] cmd, input logic has_d,
                             input logic [7:0] d, output logic ack_a, output logic ack_c,
                             output logic ack_d);
        do_start();
        send_byte({a, 1'b0}, ack_a);
        send_byte(cmd, ack_c);
        ack_d = 1'b0;
        if (has_d) send_byte(d, ack_d);
        do_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic       aa, ac, ad;
        logic [7:0] rb;
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;
        qwait();
        // R1 reset state
        check("R1 ctrl", 16'(ctrl_o), 16'h00);
        check("R1 freq", 16'(freq_o), 16'h80);
        check("R1 pdown", 16'(pdown_o), 16'h0);
        check("R1 sda_oe", 16'(sda_oe), 16'h0);

        // table walk: R3 R4 R5 R6 R7 R8 R10
        for (int v = 0; v < NV; v++) begin
            write_txn(ADDR, VEC[v].cmd, VEC[v].has_dat, VEC[v].dat, aa, ac, ad);
            check($sformatf("R2 addr ack vec %0d", v), 16'(aa), 16'h1);
            check($sformatf("R8 cmd ack vec %0d", v), 16'(ac), 16'(VEC[v].ack_c));
            if (VEC[v].has_dat)
                check($sformatf("R5/R6 data ack vec %0d", v), 16'(ad), 16'(VEC[v].ack_d));
            check($sformatf("R3/R4/R7 ctrl vec %0d", v), 16'(ctrl_o), 16'(VEC[v].ctrl));
            check($sformatf("R5/R10 freq vec %0d", v), 16'(freq_o), 16'(VEC[v].freq));
            check($sformatf("R3 pdown vec %0d", v), 16'(pdown_o), 16'(VEC[v].ctrl[0]));
        end

        // R2 wrong address: soft reset must be ignored
        write_txn(ADDR ^ 7'h01, 8'h03, 1'b0, 8'h00, aa, ac, ad);
        check("R2 foreign addr nack", 16'(aa), 16'h0);
        check("R2 foreign cmd nack", 16'(ac), 16'h0);
        check("R2 ctrl untouched", 16'(ctrl_o), 16'h03);

        // R6 second data byte after freq command
        do_start();
        send_byte({ADDR, 1'b0}, aa);
        send_byte(8'h10, ac);
        send_byte(8'h11, ad);
        check("R5 first data ack", 16'(ad), 16'h1);
        send_byte(8'h22, ad);
        check("R6 second data nack", 16'(ad), 16'h0);
        do_stop();
        check("R6 freq holds first", 16'(freq_o), 16'h11);

        // R9 read two bytes, ACK then NACK
        do_start();
        send_byte({ADDR, 1'b1}, aa);
        check("R9 read addr ack", 16'(aa), 16'h1);
        recv_byte(1'b1, rb);
        check("R9 read byte 0", 16'(rb), 16'h03);
        recv_byte(1'b0, rb);
        check("R9 read byte 1", 16'(rb), 16'h03);
        do_stop();
        check("R12 sda released after stop", 16'(sda_oe), 16'h0);

        // R11 repeated start: wake, then read back
        do_start();
        send_byte({ADDR, 1'b0}, aa);
        send_byte(8'h02, ac);
        do_start();
        send_byte({ADDR, 1'b1}, aa);
        check("R11 addr ack after Sr", 16'(aa), 16'h1);
        recv_byte(1'b0, rb);
        check("R11 read after Sr", 16'(rb), 16'h02);
        do_stop();
        check("R4 pdown cleared", 16'(pdown_o), 16'h0);

        // R1 reset in mid-run
        rst_n = 1'b0;
        qwait();
        rst_n = 1'b1;
        qwait();
        check("R1 ctrl after reset", 16'(ctrl_o), 16'h00);
        check("R1 freq after reset", 16'(freq_o), 16'h80);
        finish_run();
    end
endmodule